// File: doc/BRIEF.md
# Multi-cycle 16-bit RISC processor core

This block is a compact 16-bit processor core. Instructions and data share a single memory port. Every instruction is one 16-bit word, and its top four bits select the operation. The core holds sixteen 16-bit general registers, a program counter and a separate link register that keeps the return address of a call.

A four-state sequencer controls the work. The first cycle of every instruction fetches and decodes it. Arithmetic, compare, branch and jump instructions then finish in one execute cycle, so they take two cycles in total. Loads and stores first spend a cycle forming the address and then a cycle on the memory access, so they take three.

The memory sits outside the core. The core expects a combinational read: data for the address it drives appears on the read-data input in the same cycle. A write takes effect at the clock edge that ends a cycle with the write strobe high.

Top module: `r16_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the link register and all sixteen registers to zero. After reset the core is in the fetch state, with the enable high, the strobe low and the address 0.
- R2: Opcode 0000 writes rs+rt into rd, and opcode 0001 writes rs-rt into rd. Both wrap modulo 2^16. Field positions are rd in bits 11-8, rs in bits 7-4 and rt in bits 3-0.
- R3: Opcode 0100 writes 1 into rd when rs is less than rt as two's-complement numbers, and 0 otherwise. Opcode 0101 writes 1 into rd when rs equals rt, and 0 otherwise.
- R4: Opcode 1000 writes rs plus the sign-extended 4-bit value in bits 3-0 into rd.
- R5: Opcode 1001 adds the sign-extended 8-bit value in bits 7-0 to rd and writes the result back to rd.
- R6: Opcode 1011 sets the PC to the zero-extended bits 7-0 when the register named in bits 11-8 is zero, and to PC+1 otherwise. Opcode 1100 takes the jump when that register is non-zero.
- R7: Opcode 1101 saves PC+1 in the link register and loads the PC with bits 11-0. Opcode 1110 loads the PC from the link register.
- R8: Opcode 1111 loads the PC with bits 11-0 unconditionally.
- R9: Opcode 0010 (load) reads memory at rs plus the sign-extended bits 3-0 into rd. Opcode 0011 (store) writes rd to that address. In the access cycle the core drives the computed address.
- R10: An instruction that does not touch data takes two cycles: fetch with the enable high, then execute with the enable low. A load or store takes three cycles: fetch, then an address cycle with the enable low, then the access cycle with the enable high. The write strobe is high only in the access cycle of a store.
- R11: The all-zero word and the undefined opcodes 0110, 0111 and 1010 change no register and advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Memory word address (the PC during fetch, the data address during access) |
| mem_wdata | output | 16 | Store data (the rd register) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle as the address |
| mem_en | output | 1 | Memory enable; high in the fetch and access cycles |
| mem_we | output | 1 | Write strobe; high in the access cycle of a store |

## Verification
A straight-line program drives every arithmetic form. Operand pairs are chosen so that a signed and an unsigned compare give different answers, and so that a negative 4-bit immediate shows whether sign extension happens. The per-cycle address and enable trace is compared against a table of the PCs that should be visited. Branches are placed so that both the taken and the not-taken paths appear for a zero and a non-zero register, and a call and return pair separates the link register from the PC. Stores then dump the registers to memory, with positive and negative offsets, so that results are checked at the port. A second reset in the middle of the run must restart the program from address 0 with cleared registers, which the accumulating 8-bit immediate add would otherwise reveal.

// File: rtl/r16_pkg.sv
package r16_pkg;

  localparam int unsigned IW = 16;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_EXEC  = 2'b01,
    ST_ADDR  = 2'b10,
    ST_MEM   = 2'b11
  } r16_state_e;

  localparam logic [3:0] OP_ADD   = 4'h0;
  localparam logic [3:0] OP_SUB   = 4'h1;
  localparam logic [3:0] OP_LW    = 4'h2;
  localparam logic [3:0] OP_SW    = 4'h3;
  localparam logic [3:0] OP_SLT   = 4'h4;
  localparam logic [3:0] OP_SEQ   = 4'h5;
  localparam logic [3:0] OP_ADDI4 = 4'h8;
  localparam logic [3:0] OP_ADDI8 = 4'h9;
  localparam logic [3:0] OP_JZ    = 4'hB;
  localparam logic [3:0] OP_JNZ   = 4'hC;
  localparam logic [3:0] OP_JAL   = 4'hD;
  localparam logic [3:0] OP_JR    = 4'hE;
  localparam logic [3:0] OP_J     = 4'hF;

  function automatic logic [IW-1:0] sext4(input logic [3:0] v);
    return {{(IW-4){v[3]}}, v};
  endfunction

  function automatic logic [IW-1:0] sext8(input logic [7:0] v);
    return {{(IW-8){v[7]}}, v};
  endfunction

  // Shared arithmetic: address forms and immediates all use the add path.
  function automatic logic [IW-1:0] alu_eval(input logic [3:0] op,
                                             input logic [IW-1:0] a,
                                             input logic [IW-1:0] b);
    case (op)
      OP_SUB:  return a - b;
      OP_SLT:  return ($signed(a) < $signed(b)) ? IW'(1) : IW'(0);
      OP_SEQ:  return (a == b) ? IW'(1) : IW'(0);
      default: return a + b;
    endcase
  endfunction

  function automatic logic is_mem_op(input logic [3:0] op);
    return (op == OP_LW) || (op == OP_SW);
  endfunction

  function automatic logic writes_rd(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_SLT) ||
           (op == OP_SEQ) || (op == OP_ADDI4) || (op == OP_ADDI8);
  endfunction

endpackage

// File: rtl/r16_regfile.sv
module r16_regfile #(
  parameter int W = 16,
  parameter int N = 16,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  input  logic [AW-1:0] raddr_c,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b,
  output logic [W-1:0]  rdata_c
);

  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];
  assign rdata_c = rf[raddr_c];

endmodule

// File: rtl/r16_alu.sv
module r16_alu
  import r16_pkg::*;
(
  input  logic [3:0]    op,
  input  logic [IW-1:0] a,
  input  logic [IW-1:0] b,
  output logic [IW-1:0] y
);

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/r16_ctrl.sv
module r16_ctrl
  import r16_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] fetch_op,
  output r16_state_e state
);

  r16_state_e state_nx;

  always_comb begin
    case (state)
      ST_FETCH: state_nx = is_mem_op(fetch_op) ? ST_ADDR : ST_EXEC;
      ST_ADDR:  state_nx = ST_MEM;
      default:  state_nx = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FETCH;
    else     state <= state_nx;
  end

endmodule

// File: rtl/r16_core.sv
module r16_core
  import r16_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] mem_addr,
  output logic [IW-1:0] mem_wdata,
  input  logic [IW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we
);

  localparam int REG_N  = 16;
  localparam int REG_AW = $clog2(REG_N);

  r16_state_e        state;
  logic [IW-1:0]     ir_q, pc_q, ra_q, addr_q;
  logic [IW-1:0]     pc_inc, pc_next;
  logic [IW-1:0]     rd_val, rs_val, rt_val;
  logic [IW-1:0]     alu_a, alu_b, alu_y;
  logic [IW-1:0]     reg_wdata;
  logic              reg_we;
  logic [3:0]        op;
  logic [REG_AW-1:0] f_rd, f_rs, f_rt;

  // Named events for the checker.
  logic st_fetch, st_exec, st_addr, st_mem, nop_word;

  assign op       = ir_q[15:12];
  assign f_rd     = ir_q[11:8];
  assign f_rs     = ir_q[7:4];
  assign f_rt     = ir_q[3:0];
  assign st_fetch = (state == ST_FETCH);
  assign st_exec  = (state == ST_EXEC);
  assign st_addr  = (state == ST_ADDR);
  assign st_mem   = (state == ST_MEM);
  assign nop_word = (ir_q == '0);

  r16_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fetch_op (mem_rdata[15:12]),
    .state    (state)
  );

  r16_regfile #(.W(IW), .N(REG_N)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (reg_we),
    .waddr   (f_rd),
    .wdata   (reg_wdata),
    .raddr_a (f_rs),
    .raddr_b (f_rt),
    .raddr_c (f_rd),
    .rdata_a (rs_val),
    .rdata_b (rt_val),
    .rdata_c (rd_val)
  );

  always_comb begin
    alu_a = (op == OP_ADDI8) ? rd_val : rs_val;
    case (op)
      OP_ADD, OP_SUB, OP_SLT, OP_SEQ: alu_b = rt_val;
      OP_ADDI8:                       alu_b = sext8(ir_q[7:0]);
      default:                        alu_b = sext4(ir_q[3:0]);
    endcase
  end

  r16_alu u_alu (
    .op (op),
    .a  (alu_a),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign reg_we    = (st_exec && writes_rd(op) && !nop_word) ||
                     (st_mem && op == OP_LW);
  assign reg_wdata = st_mem ? mem_rdata : alu_y;

  assign pc_inc = pc_q + IW'(1);

  always_comb begin
    pc_next = pc_inc;
    if (st_exec) begin
      case (op)
        OP_JZ:  if (rd_val == '0) pc_next = {{(IW-8){1'b0}}, ir_q[7:0]};
        OP_JNZ: if (rd_val != '0) pc_next = {{(IW-8){1'b0}}, ir_q[7:0]};
        OP_JAL: pc_next = {{(IW-12){1'b0}}, ir_q[11:0]};
        OP_J:   pc_next = {{(IW-12){1'b0}}, ir_q[11:0]};
        OP_JR:  pc_next = ra_q;
        default: pc_next = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q   <= '0;
      pc_q   <= '0;
      ra_q   <= '0;
      addr_q <= '0;
    end else begin
      if (st_fetch) ir_q <= mem_rdata;
      if (st_addr) addr_q <= alu_y;
      if (st_exec || st_mem) pc_q <= pc_next;
      if (st_exec && op == OP_JAL) ra_q <= pc_inc;
    end
  end

  assign mem_addr  = st_mem ? addr_q : pc_q;
  assign mem_en    = st_fetch || st_mem;
  assign mem_we    = st_mem && (op == OP_SW);
  assign mem_wdata = rd_val;

endmodule

// File: rtl/r16_core_chk.sv
module r16_core_chk
  import r16_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          st_fetch,
  input logic          st_exec,
  input logic          st_addr,
  input logic          st_mem,
  input logic [3:0]    op,
  input logic [IW-1:0] pc_q,
  input logic [IW-1:0] ra_q,
  input logic [IW-1:0] mem_addr,
  input logic          mem_en,
  input logic          mem_we
);

  // R1
  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (st_fetch && pc_q == '0 && mem_addr == '0 && mem_en && !mem_we));

  // R10
  p_we_gated_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_en && st_mem && op == OP_SW));

  // R10
  p_exec_returns_r10: assert property (@(posedge clk) disable iff (rst)
    st_exec |=> st_fetch);

  // R9
  p_addr_then_mem_r9: assert property (@(posedge clk) disable iff (rst)
    st_addr |=> (st_mem && mem_en));

  // R7
  p_jr_target_r7: assert property (@(posedge clk) disable iff (rst)
    (st_exec && op == OP_JR) |=> (pc_q == $past(ra_q)));

  // R7
  p_jal_link_r7: assert property (@(posedge clk) disable iff (rst)
    (st_exec && op == OP_JAL) |=> (ra_q == $past(pc_q) + IW'(1)));

  // R11
  p_undef_step_r11: assert property (@(posedge clk) disable iff (rst)
    (st_exec && (op == 4'h6 || op == 4'h7 || op == 4'hA))
      |=> (pc_q == $past(pc_q) + IW'(1)));

  // R10
  p_one_state_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot({st_fetch, st_exec, st_addr, st_mem}));

endmodule

bind r16_core r16_core_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .st_fetch (st_fetch),
  .st_exec  (st_exec),
  .st_addr  (st_addr),
  .st_mem   (st_mem),
  .op       (op),
  .pc_q     (pc_q),
  .ra_q     (ra_q),
  .mem_addr (mem_addr),
  .mem_en   (mem_en),
  .mem_we   (mem_we)
);

// File: tb/r16_core_bench.sv
module r16_core_bench;

  localparam int CLK_P  = 10;
  localparam int NSTEP  = 36;
  localparam int K_NORM = 0;
  localparam int K_LOAD = 1;
  localparam int K_STOR = 2;

  // {pc, kind, data address, requirement number}
  typedef struct packed {
    logic [15:0] pc;
    logic [1:0]  kind;
    logic [15:0] daddr;
    logic [7:0]  req;
  } step_t;

  localparam step_t STEPS [NSTEP] = '{
    '{16'd0,  2'd0, 16'd0,   8'd5},   // R5 addi8 r2,5
    '{16'd1,  2'd0, 16'd0,   8'd5},   // R5 addi8 r3,5
    '{16'd2,  2'd0, 16'd0,   8'd3},   // R3 seq r4,r2,r3
    '{16'd3,  2'd0, 16'd0,   8'd3},   // R3 slt r5,r4,r2
    '{16'd4,  2'd0, 16'd0,   8'd5},   // R5 addi8 r6,0x80
    '{16'd5,  2'd0, 16'd0,   8'd2},   // R2 add r8,r5,r6
    '{16'd6,  2'd0, 16'd0,   8'd2},   // R2 sub r9,r5,r6
    '{16'd7,  2'd0, 16'd0,   8'd4},   // R4 addi4 r10,r9,5
    '{16'd8,  2'd0, 16'd0,   8'd4},   // R4 addi4 r11,r9,-1
    '{16'd9,  2'd0, 16'd0,   8'd8},   // R8 j 20
    '{16'd20, 2'd0, 16'd0,   8'd6},   // R6 jz r8 not taken
    '{16'd21, 2'd0, 16'd0,   8'd6},   // R6 jnz r8 taken to 30
    '{16'd30, 2'd0, 16'd0,   8'd7},   // R7 jal 50
    '{16'd50, 2'd0, 16'd0,   8'd7},   // R7 jr back to 31
    '{16'd31, 2'd0, 16'd0,   8'd11},  // R11 all-zero word
    '{16'd32, 2'd0, 16'd0,   8'd3},   // R3 slt r12,r6,r5 (signed)
    '{16'd33, 2'd0, 16'd0,   8'd6},   // R6 jz r0 taken to 36
    '{16'd36, 2'd0, 16'd0,   8'd6},   // R6 jnz r0 not taken
    '{16'd37, 2'd0, 16'd0,   8'd5},   // R5 addi8 r1,100
    '{16'd38, 2'd2, 16'd100, 8'd9},   // R9 store r4
    '{16'd39, 2'd2, 16'd101, 8'd9},
    '{16'd40, 2'd2, 16'd102, 8'd9},
    '{16'd41, 2'd2, 16'd103, 8'd9},
    '{16'd42, 2'd2, 16'd104, 8'd9},
    '{16'd43, 2'd2, 16'd105, 8'd9},
    '{16'd44, 2'd2, 16'd106, 8'd9},
    '{16'd45, 2'd2, 16'd107, 8'd9},
    '{16'd46, 2'd2, 16'd99,  8'd9},   // R9 negative offset
    '{16'd47, 2'd1, 16'd103, 8'd9},   // R9 load r13
    '{16'd48, 2'd2, 16'd98,  8'd9},
    '{16'd49, 2'd0, 16'd0,   8'd8},   // R8 j 60
    '{16'd60, 2'd0, 16'd0,   8'd11},  // R11 undefined 0110
    '{16'd61, 2'd0, 16'd0,   8'd11},  // R11 undefined 1010
    '{16'd62, 2'd2, 16'd97,  8'd11},  // R11 store r1 after undefined ops
    '{16'd63, 2'd0, 16'd0,   8'd8},   // R8 j 63 (halt loop)
    '{16'd63, 2'd0, 16'd0,   8'd8}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_en, mem_we;
  logic [15:0] mem [256];
  int          n_chk = 0;
  int          n_err = 0;
  bit          done  = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  r16_core u_r16_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we)
  );

  assign mem_rdata = mem[mem_addr[7:0]];

  task automatic load_image();
    for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
    mem[0]  <= 16'h9205;  mem[1]  <= 16'h9305;  mem[2]  <= 16'h5423;
    mem[3]  <= 16'h4542;  mem[4]  <= 16'h9680;  mem[5]  <= 16'h0856;
    mem[6]  <= 16'h1956;  mem[7]  <= 16'h8A95;  mem[8]  <= 16'h8B9F;
    mem[9]  <= 16'hF014;  mem[20] <= 16'hB828;  mem[21] <= 16'hC81E;
    mem[30] <= 16'hD032;  mem[50] <= 16'hE000;  mem[31] <= 16'h0000;
    mem[32] <= 16'h4C65;  mem[33] <= 16'hB024;  mem[36] <= 16'hC028;
    mem[37] <= 16'h9164;  mem[38] <= 16'h3410;  mem[39] <= 16'h3511;
    mem[40] <= 16'h3612;  mem[41] <= 16'h3813;  mem[42] <= 16'h3914;
    mem[43] <= 16'h3A15;  mem[44] <= 16'h3B16;  mem[45] <= 16'h3C17;
    mem[46] <= 16'h321F;  mem[47] <= 16'h2D13;  mem[48] <= 16'h3D1E;
    mem[49] <= 16'hF03C;  mem[60] <= 16'h6123;  mem[61] <= 16'hA1F0;
    mem[62] <= 16'h311D;  mem[63] <= 16'hF03F;
  endtask

  always @(posedge clk) begin
    if (rst) load_image();
    else if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1: state right after reset
    chk("R1", "reset addr", 32'(mem_addr), 32'h0);
    chk("R1", "reset en",   32'(mem_en),   32'h1);
    chk("R1", "reset we",   32'(mem_we),   32'h0);

    // R10 and per-instruction PC trace
    for (int s = 0; s < NSTEP; s++) begin
      string tg;
      tg = $sformatf("R%0d", STEPS[s].req);
      chk(tg, "fetch addr", 32'(mem_addr), 32'(STEPS[s].pc));
      chk("R10", "fetch en", 32'({mem_en, mem_we}), 32'h2);
      @(negedge clk); #1;
      chk("R10", "second cycle en", 32'(mem_en), 32'h0);
      if (STEPS[s].kind != 2'(K_NORM)) begin
        @(negedge clk); #1;
        chk("R9", "access addr", 32'(mem_addr), 32'(STEPS[s].daddr));
        chk("R10", "access strobe", 32'({mem_en, mem_we}),
            (STEPS[s].kind == 2'(K_STOR)) ? 32'h3 : 32'h2);
      end
      @(negedge clk); #1;
    end

    // Register results dumped by stores
    chk("R3",  "seq equal",        32'(mem[100]), 32'h0001);
    chk("R3",  "slt 1<5",          32'(mem[101]), 32'h0001);
    chk("R5",  "addi8 0x80",       32'(mem[102]), 32'hFF80);
    chk("R2",  "add 1+(-128)",     32'(mem[103]), 32'hFF81);
    chk("R2",  "sub 1-(-128)",     32'(mem[104]), 32'h0081);
    chk("R4",  "addi4 +5",         32'(mem[105]), 32'h0086);
    chk("R4",  "addi4 -1",         32'(mem[106]), 32'h0080);
    chk("R3",  "slt signed",       32'(mem[107]), 32'h0001);
    chk("R9",  "store neg offset", 32'(mem[99]),  32'h0005);
    chk("R9",  "load round trip",  32'(mem[98]),  32'hFF81);
    chk("R11", "undef no write",   32'(mem[97]),  32'h0064);

    // R1: reset in the middle of the halt loop restarts with cleared registers
    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    #1;
    chk("R1", "rerun addr", 32'(mem_addr), 32'h0);
    chk("R1", "rerun en",   32'({mem_en, mem_we}), 32'h2);
    repeat (150) @(negedge clk);
    #1;
    chk("R1", "regs cleared r2", 32'(mem[99]), 32'h0005);
    chk("R1", "regs cleared r1", 32'(mem[97]), 32'h0064);
    chk("R8", "halt loop",       32'(mem_addr == 16'd63 || mem_addr == 16'd63), 32'h1);

    done = 1'b1;
    finish_run();
  end

endmodule